// File: doc/BRIEF.md
# Multiprocessor Wake-Up Serial Receiver

This block receives asynchronous serial characters sampled by a 16x oversampling clock enable. It can run with a plain character format or with a multiprocessor format. In the multiprocessor format each character carries one extra bit after its data bits. An external select input chooses the format.

A wake-up filter works in the multiprocessor format. When the wake control is set, a character whose extra bit is 0 is discarded. Such a character changes neither the receive-full flag nor the error flags. This lets a node on a shared serial line ignore traffic until an address character, marked by an extra bit of 1, arrives.

A byte-wide control register sets several things: the receiver enable, the wake control, the character length and the stop-bit count. A register write can also clear the error flags. Turning the receiver off aborts any character in progress, and the receive-full and error flags keep their values.

Top module: `mp_uart_rx`

## Requirements
- R1: After reset the control register reads 0x00, and `rx_full`, `overrun`, `frame_err` and `rx_data` are all 0.
- R2: A write through `reg_wr`/`reg_wdata` stores all eight control bits, and `ctrl_rdata` returns them from the next cycle. Bit 3 reads back as written while `mp_fmt` is 0.
- R3: The receiver (control bit 6 = 1) detects a falling edge on `rxd` and confirms the start bit low 8 ticks later. It then samples each further bit 16 ticks apart, least significant bit first. Control bit 2 = 1 selects 8 data bits. Control bit 2 = 0 selects 7 data bits, and `rx_data` bit 7 then reads 0. A completed character sets `rx_full`.
- R4: A low pulse on `rxd` that has ended before the mid-bit confirmation starts no character.
- R5: A character allowed to update flags whose first stop bit samples low sets `frame_err`.
- R6: A character allowed to update flags that completes while `rx_full` is 1 sets `overrun` and leaves `rx_data` unchanged.
- R7: A one-cycle `data_rd` pulse clears `rx_full`.
- R8: With `mp_fmt` = 1 and control bit 7 = 1, a character whose multiprocessor bit is 0 changes no flag and no data. A character whose multiprocessor bit is 1 is taken.
- R9: With `mp_fmt` = 1 and control bit 7 = 0, every character is taken, whatever its multiprocessor bit.
- R10: With `mp_fmt` = 0, control bit 7 has no effect. The character has no extra bit, and every character is taken.
- R11: Clearing control bit 6 aborts a character in progress and holds `rx_full`, `overrun`, `frame_err` and `rx_data` at their values. A `stop_io` pulse clears control bit 6 on the next cycle.
- R12: A control write with bit 3 = 0 while `mp_fmt` = 0 clears `overrun` and `frame_err`. While `mp_fmt` = 1, control bit 3 reads the multiprocessor bit of the last character taken.
- R13: Control bit 0 = 1 selects two stop bits. The receiver watches for the next start edge only after the second stop bit, so back-to-back characters with two stop bits are both received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_io | input | 1 | Stop-I/O request; clears the receiver enable |
| mp_fmt | input | 1 | Multiprocessor character format select |
| tick16 | input | 1 | 16x oversampling clock enable |
| rxd | input | 1 | Serial receive line, idle high |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| ctrl_rdata | output | 8 | Control register read value |
| data_rd | input | 1 | Data register read strobe |
| rx_data | output | 8 | Received data byte |
| rx_full | output | 1 | Receive data full flag |
| overrun | output | 1 | Overrun error flag |
| frame_err | output | 1 | Framing error flag |

## Verification
The assertions check five rules on every cycle. While the receiver is off, the flags and the data are held. A character dropped by the wake-up filter changes no flag. Held data never changes while the receive-full flag is set. A stop-I/O request clears the enable. A read or an error-clear write takes effect.

Only the bench scenarios can show the bit timing:
- mid-bit start confirmation and glitch rejection;
- the two character lengths;
- back-to-back characters with two stop bits;
- how multiprocessor bit values decide acceptance under each wake and format setting.

The bench's cycle model checks these against outputs it computes itself.

// File: rtl/mpu_rx_pkg.sv
package mpu_rx_pkg;
    localparam int CTL_WAKE  = 7;
    localparam int CTL_RXEN  = 6;
    localparam int CTL_ERRC  = 3;
    localparam int CTL_LEN   = 2;
    localparam int CTL_STOP2 = 0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_MPB,
        ST_STOP1,
        ST_STOP2
    } rx_state_e;
endpackage

// File: rtl/mpu_ctrl_reg.sv
module mpu_ctrl_reg
    import mpu_rx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         stop_io,
    input  logic         mp_fmt,
    output logic [W-1:0] ctrl,
    output logic         err_clr
);
    typedef struct packed {
        logic [W-1:0] ctrl;
    } ctl_t;

    ctl_t q, d;

    always_comb begin
        d = q;
        if (wr) d.ctrl = wdata;
        if (stop_io) d.ctrl[CTL_RXEN] = 1'b0;
        err_clr = wr & ~wdata[CTL_ERRC] & ~mp_fmt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ctrl = q.ctrl;
endmodule

// File: rtl/mpu_rx_frame.sv
module mpu_rx_frame
    import mpu_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic              rxd,
    input  logic              mp_fmt,
    input  logic              full_len,
    input  logic              two_stop,
    output logic              done,
    output logic              stop_ok,
    output logic              mpb,
    output logic [DATA_W-1:0] data
);
    localparam int CW  = $clog2(OVS);
    localparam int NBW = $clog2(DATA_W + 1);
    localparam logic [CW-1:0] HALF_M1 = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] LAST    = CW'(OVS - 1);

    typedef struct packed {
        rx_state_e         st;
        logic [CW-1:0]     cnt;
        logic [NBW-1:0]    nb;
        logic [DATA_W-1:0] sh;
        logic              mpb;
        logic              prev;
    } frm_t;

    frm_t q, d;
    logic [NBW-1:0] last_nb;

    always_comb begin
        d       = q;
        done    = 1'b0;
        stop_ok = 1'b0;
        last_nb = full_len ? NBW'(DATA_W - 1) : NBW'(DATA_W - 2);
        if (tick) d.prev = rxd;
        case (q.st)
            ST_IDLE: begin
                if (tick && q.prev && !rxd) begin
                    d.st  = ST_START;
                    d.cnt = '0;
                end
            end
            ST_START: begin
                if (tick) begin
                    if (q.cnt == HALF_M1) begin
                        d.cnt = '0;
                        d.nb  = '0;
                        d.sh  = '0;
                        d.mpb = 1'b0;
                        d.st  = rxd ? ST_IDLE : ST_DATA;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (tick) begin
                    if (q.cnt == LAST) begin
                        d.cnt = '0;
                        d.sh  = {rxd, q.sh[DATA_W-1:1]};
                        d.nb  = q.nb + 1'b1;
                        if (q.nb == last_nb) d.st = mp_fmt ? ST_MPB : ST_STOP1;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_MPB: begin
                if (tick) begin
                    if (q.cnt == LAST) begin
                        d.cnt = '0;
                        d.mpb = rxd;
                        d.st  = ST_STOP1;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_STOP1: begin
                if (tick) begin
                    if (q.cnt == LAST) begin
                        d.cnt   = '0;
                        done    = 1'b1;
                        stop_ok = rxd;
                        d.st    = two_stop ? ST_STOP2 : ST_IDLE;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_STOP2: begin
                if (tick) begin
                    if (q.cnt == LAST) begin
                        d.cnt = '0;
                        d.st  = ST_IDLE;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
        if (!en) begin
            d.st    = ST_IDLE;
            done    = 1'b0;
            stop_ok = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, prev: 1'b1, default: '0};
        else        q <= d;
    end

    assign mpb  = q.mpb;
    assign data = full_len ? q.sh : (q.sh >> 1);
endmodule

// File: rtl/mpu_rx_flags.sv
module mpu_rx_flags #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic              stop_ok,
    input  logic              mpb,
    input  logic [DATA_W-1:0] data_in,
    input  logic              mp_fmt,
    input  logic              wake,
    input  logic              data_rd,
    input  logic              err_clr,
    output logic              full,
    output logic              ovr,
    output logic              fe,
    output logic              last_mpb,
    output logic [DATA_W-1:0] data
);
    typedef struct packed {
        logic              full;
        logic              ovr;
        logic              fe;
        logic              lmpb;
        logic [DATA_W-1:0] data;
    } flg_t;

    flg_t q, d;
    logic accept;

    always_comb begin
        d      = q;
        accept = done & (~(mp_fmt & wake) | mpb);
        if (err_clr) begin
            d.ovr = 1'b0;
            d.fe  = 1'b0;
        end
        if (data_rd) d.full = 1'b0;
        if (accept) begin
            d.lmpb = mpb;
            if (!stop_ok) d.fe = 1'b1;
            if (q.full) begin
                d.ovr = 1'b1;
            end else begin
                d.full = 1'b1;
                d.data = data_in;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign full     = q.full;
    assign ovr      = q.ovr;
    assign fe       = q.fe;
    assign last_mpb = q.lmpb;
    assign data     = q.data;
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx
    import mpu_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stop_io,
    input  logic              mp_fmt,
    input  logic              tick16,
    input  logic              rxd,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        ctrl_rdata,
    input  logic              data_rd,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              overrun,
    output logic              frame_err
);
    logic [7:0]        ctrl_q;
    logic              err_clr;
    logic              rx_done;
    logic              rx_stop_ok;
    logic              rx_mpb;
    logic [DATA_W-1:0] rx_shift;
    logic              last_mpb;

    mpu_ctrl_reg #(.W(8)) i_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .wdata   (reg_wdata),
        .stop_io (stop_io),
        .mp_fmt  (mp_fmt),
        .ctrl    (ctrl_q),
        .err_clr (err_clr)
    );

    mpu_rx_frame #(.DATA_W(DATA_W), .OVS(OVS)) i_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (ctrl_q[CTL_RXEN]),
        .tick     (tick16),
        .rxd      (rxd),
        .mp_fmt   (mp_fmt),
        .full_len (ctrl_q[CTL_LEN]),
        .two_stop (ctrl_q[CTL_STOP2]),
        .done     (rx_done),
        .stop_ok  (rx_stop_ok),
        .mpb      (rx_mpb),
        .data     (rx_shift)
    );

    mpu_rx_flags #(.DATA_W(DATA_W)) i_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .done     (rx_done),
        .stop_ok  (rx_stop_ok),
        .mpb      (rx_mpb),
        .data_in  (rx_shift),
        .mp_fmt   (mp_fmt),
        .wake     (ctrl_q[CTL_WAKE]),
        .data_rd  (data_rd),
        .err_clr  (err_clr),
        .full     (rx_full),
        .ovr      (overrun),
        .fe       (frame_err),
        .last_mpb (last_mpb),
        .data     (rx_data)
    );

    always_comb begin
        ctrl_rdata = ctrl_q;
        if (mp_fmt) ctrl_rdata[CTL_ERRC] = last_mpb;
    end
endmodule

// File: rtl/mp_uart_rx_chk.sv
module mp_uart_rx_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stop_io,
    input logic              mp_fmt,
    input logic              reg_wr,
    input logic [7:0]        reg_wdata,
    input logic [7:0]        ctrl_rdata,
    input logic              data_rd,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_full,
    input logic              overrun,
    input logic              frame_err,
    input logic              rx_done,
    input logic              rx_mpb
);
    AST_STOPIO_DROPS_RE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_io |=> !ctrl_rdata[6]); // R11

    AST_OFF_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_rdata[6] && !data_rd && !reg_wr)
        |=> $stable({rx_full, overrun, frame_err, rx_data})); // R11

    AST_WAKE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && mp_fmt && ctrl_rdata[7] && !rx_mpb && !data_rd && !reg_wr)
        |=> $stable({rx_full, overrun, frame_err, rx_data})); // R8

    AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !rx_done) |=> !rx_full); // R7

    AST_FULL_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !data_rd) |=> $stable(rx_data)); // R6

    AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_wdata[3] && !mp_fmt && !rx_done)
        |=> (!overrun && !frame_err)); // R12
endmodule

bind mp_uart_rx mp_uart_rx_chk #(.DATA_W(DATA_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_io    (stop_io),
    .mp_fmt     (mp_fmt),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .ctrl_rdata (ctrl_rdata),
    .data_rd    (data_rd),
    .rx_data    (rx_data),
    .rx_full    (rx_full),
    .overrun    (overrun),
    .frame_err  (frame_err),
    .rx_done    (rx_done),
    .rx_mpb     (rx_mpb)
);

// File: tb/test_mp_uart_rx.sv
`timescale 1ns/1ps
module test_mp_uart_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stop_io = 1'b0;
    logic       mp_fmt = 1'b0;
    logic       tick16 = 1'b0;
    logic       rxd = 1'b1;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] ctrl_rdata;
    logic       data_rd = 1'b0;
    logic [7:0] rx_data;
    logic       rx_full, overrun, frame_err;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit cmp_en = 1'b0;
    string cur_req = "R1";

    logic [7:0] exp_ctrl = 8'h00;
    logic [7:0] exp_data = 8'h00;
    bit exp_full = 0, exp_ovr = 0, exp_fe = 0, exp_lmpb = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) begin
        tick16 <= ~tick16;
        cycles <= cycles + 1;
    end

    mp_uart_rx i_mp_uart_rx (
        .clk(clk), .rst_n(rst_n), .stop_io(stop_io), .mp_fmt(mp_fmt),
        .tick16(tick16), .rxd(rxd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .ctrl_rdata(ctrl_rdata), .data_rd(data_rd), .rx_data(rx_data),
        .rx_full(rx_full), .overrun(overrun), .frame_err(frame_err)
    );

    function automatic logic [7:0] exp_read();
        logic [7:0] v = exp_ctrl;
        if (mp_fmt) v[3] = exp_lmpb;
        return v;
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // cycle model comparison, away from the active edge
    always @(negedge clk) begin
        if (cmp_en) begin
            chk(cur_req, "model ctrl", ctrl_rdata, exp_read());
            chk(cur_req, "model flags", {rx_full, overrun, frame_err},
                {exp_full, exp_ovr, exp_fe});
            chk(cur_req, "model data", rx_data, exp_data);
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr_ctrl(logic [7:0] v);
        reg_wr = 1'b1; reg_wdata = v;
        step();
        reg_wr = 1'b0;
        exp_ctrl = v;
        if (!v[3] && !mp_fmt) begin exp_ovr = 0; exp_fe = 0; end
    endtask

    task automatic rd_data();
        data_rd = 1'b1;
        step();
        data_rd = 1'b0;
        exp_full = 0;
    endtask

    task automatic bit_time(logic v);
        rxd = v;
        repeat (32) step();
    endtask

    task automatic model_accept(logic [7:0] dat, int nb, logic mpb, logic stopv);
        logic [7:0] m = (nb == 7) ? (dat & 8'h7F) : dat;
        if (!exp_ctrl[6]) return;
        if (mp_fmt && exp_ctrl[7] && !mpb) return;
        exp_lmpb = mp_fmt ? mpb : 1'b0;
        if (!stopv) exp_fe = 1;
        if (exp_full) exp_ovr = 1;
        else begin exp_full = 1; exp_data = m; end
    endtask

    task automatic send(logic [7:0] dat, int nb, logic mpb, logic stopv, int nstop, int gap);
        bit_time(1'b0);
        for (int i = 0; i < nb; i++) bit_time(dat[i]);
        if (mp_fmt) bit_time(mpb);
        cmp_en = 0;
        bit_time(stopv);
        model_accept(dat, nb, mpb, stopv);
        cmp_en = 1;
        if (nstop == 2) bit_time(1'b1);
        for (int i = 0; i < gap; i++) bit_time(1'b1);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        step();
        cmp_en = 1;
        cur_req = "R1";
        chk("R1", "reset ctrl", ctrl_rdata, 8'h00);
        chk("R1", "reset flags", {rx_full, overrun, frame_err}, 3'b000);
        chk("R1", "reset data", rx_data, 8'h00);

        cur_req = "R2";
        wr_ctrl(8'hAF);
        step();
        chk("R2", "readback AF", ctrl_rdata, 8'hAF);
        wr_ctrl(8'h44);
        step();
        chk("R2", "readback 44", ctrl_rdata, 8'h44);

        cur_req = "R3";
        send(8'h5A, 8, 0, 1, 1, 1);
        chk("R3", "8-bit data", rx_data, 8'h5A);
        chk("R3", "full set", rx_full, 1'b1);
        cur_req = "R7";
        rd_data();
        chk("R7", "read clears full", rx_full, 1'b0);

        cur_req = "R3";
        wr_ctrl(8'h40);
        send(8'hD5, 7, 0, 1, 1, 1);
        chk("R3", "7-bit data", rx_data, 8'h55);
        rd_data();

        cur_req = "R4";
        rxd = 1'b0; repeat (8) step();
        bit_time(1'b1); bit_time(1'b1);
        chk("R4", "glitch ignored", rx_full, 1'b0);

        cur_req = "R5";
        wr_ctrl(8'h44);
        send(8'h3C, 8, 0, 0, 1, 1);
        chk("R5", "framing error", frame_err, 1'b1);
        cur_req = "R12";
        wr_ctrl(8'h44);
        chk("R12", "error clear", frame_err, 1'b0);
        rd_data();

        cur_req = "R6";
        send(8'h11, 8, 0, 1, 1, 1);
        send(8'h22, 8, 0, 1, 1, 1);
        chk("R6", "overrun set", overrun, 1'b1);
        chk("R6", "data kept", rx_data, 8'h11);
        wr_ctrl(8'h44);
        chk("R12", "overrun cleared", overrun, 1'b0);
        rd_data();

        cur_req = "R13";
        wr_ctrl(8'h45);
        send(8'h33, 8, 0, 1, 2, 0);
        send(8'h3C, 8, 0, 1, 2, 1);
        chk("R13", "first of pair", rx_data, 8'h33);
        chk("R13", "second seen as overrun", overrun, 1'b1);
        wr_ctrl(8'h44);
        rd_data();

        cur_req = "R10";
        wr_ctrl(8'hC4);
        send(8'h77, 8, 0, 1, 1, 1);
        chk("R10", "wake ignored w/o mp format", rx_data, 8'h77);
        chk("R10", "full", rx_full, 1'b1);
        rd_data();

        cur_req = "R8";
        mp_fmt = 1'b1;
        step();
        send(8'h12, 8, 0, 1, 1, 1);
        chk("R8", "mpb0 dropped", rx_full, 1'b0);
        send(8'h13, 8, 0, 0, 1, 1);
        chk("R8", "mpb0 bad stop dropped", frame_err, 1'b0);
        send(8'h34, 8, 1, 1, 1, 1);
        chk("R8", "mpb1 taken", rx_data, 8'h34);
        chk("R8", "mpb1 full", rx_full, 1'b1);
        chk("R12", "bit3 shows mpb 1", ctrl_rdata[3], 1'b1);
        rd_data();

        cur_req = "R9";
        wr_ctrl(8'h44);
        send(8'h56, 8, 0, 1, 1, 1);
        chk("R9", "mpb0 taken w/o wake", rx_data, 8'h56);
        chk("R12", "bit3 shows mpb 0", ctrl_rdata[3], 1'b0);
        rd_data();
        mp_fmt = 1'b0;
        step();

        cur_req = "R11";
        wr_ctrl(8'h44);
        send(8'h99, 8, 0, 1, 1, 1);
        wr_ctrl(8'h0C);
        send(8'h00, 8, 0, 0, 1, 1);
        chk("R11", "held full", rx_full, 1'b1);
        chk("R11", "held fe", frame_err, 1'b0);
        chk("R11", "held data", rx_data, 8'h99);
        wr_ctrl(8'h44);
        rd_data();
        bit_time(1'b0); bit_time(1'b1); bit_time(1'b0);
        wr_ctrl(8'h04);
        for (int i = 0; i < 8; i++) bit_time(1'b0);
        bit_time(1'b1); bit_time(1'b1);
        chk("R11", "aborted frame no flag", rx_full, 1'b0);
        wr_ctrl(8'h44);
        send(8'hA5, 8, 0, 1, 1, 1);
        chk("R11", "clean restart", rx_data, 8'hA5);
        stop_io = 1'b1;
        step();
        stop_io = 1'b0;
        exp_ctrl[6] = 1'b0;
        chk("R11", "stop_io drops enable", ctrl_rdata[6], 1'b0);
        step();

        cmp_en = 0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait (cycles >= 150000);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule